// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block collects interrupt requests from 32 general-purpose input pins and presents them to a processor as one combined interrupt line. It also gives the number of the pin that software should service first. Each pin is configured on its own. It can be level-sensitive, asserting while high or while low. It can also be edge-sensitive, detecting rising edges, falling edges or both. An edge pin can either latch its event until software clears it or report it only for the cycle in which it is detected.

Software reaches the configuration and status through a 16-bit register port. Every 32-bit register is seen as two halfwords. The lower halfword holds pins 0 to 15 and the upper halfword holds pins 16 to 31. Pending status is cleared by writing ones. Every pin input is resynchronised to the block clock before any detection takes place. A fixed priority encoder reports the lowest-numbered pin that is both pending and enabled, together with a valid flag. The flag lets software tell a spurious interrupt apart from a real one.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, every register (enable, type, level, hold, falling, rising, status) holds zero, `irq_o` and `irq_valid_o` are low and `irq_pin_o` is 0.
- R2: Halfword addresses: status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, level 0x14/0x16, hold 0x18/0x1A, falling-edge 0x20/0x22, rising-edge 0x24/0x26. The first address of each pair holds pins 0-15 in bits 0-15. The second holds pins 16-31 in bits 0-15. A written configuration halfword reads back unchanged on `reg_rdata_o`, and the other half is not affected.
- R3: A pin with type bit 0 is level-sensitive. It is pending while its synchronised input equals its level bit (1 = active high, 0 = active low). A pin change driven before clock edge k shows in status on edge k+2. Status follows the input back down with the same delay.
- R4: A pin with type bit 1 detects an event on a rising edge when its rising bit is set, and on a falling edge when its falling bit is set. With both bits set it detects either edge. With neither bit set it never becomes pending.
- R5: On an edge pin with hold bit 1, a detected event stays in status until a 1 is written to that status bit. Writing 0 leaves it set.
- R6: On an edge pin with hold bit 0, status is high for exactly one cycle per detected event.
- R7: Writing 1 to a status bit clears it. If a new event occurs on that bit in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some pin has both its status bit and its enable bit set.
- R9: When `irq_valid_o` is high, `irq_pin_o` is the lowest-numbered pin that is both pending and enabled. Pins 0-15 are searched before pins 16-31, and a pin from the upper half is reported as its bit index plus 16.
- R10: When no pin is both pending and enabled, `irq_valid_o` is low and `irq_pin_o` is 0.
- R11: Writes to addresses outside the map change nothing, and reads from them return 0. Writing ones to status never sets a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Asynchronous pin inputs |
| reg_wr_i | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_addr_i | input | 6 | Byte address of the halfword register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| irq_valid_o | output | 1 | A pending and enabled pin exists |
| irq_pin_o | output | 5 | Number of the highest-priority pending and enabled pin |

## Verification
The checker watches these properties on every cycle:
- the combined line and the encoder's valid flag always agree;
- a reported pin is always pending and enabled, and no lower-numbered pin qualifies;
- the pin number is zero whenever nothing is valid;
- a held edge event never drops unless its status bit is written with a one;
- configuration is cleared on the first clock after reset.

Some behaviours depend on pin waveforms and on timing, so only the bench scenarios show them:
- the three-edge latency through the synchroniser;
- which edge polarity each select combination detects;
- the single-cycle pulse of unheld edges;
- the same-cycle race between a clear and a new event;
- the isolation of the two halfword halves.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 6;

    // Register selected by a halfword address
    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_EN,
        SEL_TYPE,
        SEL_LVL,
        SEL_HOLD,
        SEL_FALL,
        SEL_RISE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    // Byte offset of the lower halfword of each register
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_EN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_TYPE = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_LVL  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_HOLD = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_FALL = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_RISE = 6'h24;

    function automatic reg_dec_t decode_addr(logic [ADDR_W-1:0] addr);
        reg_dec_t          d;
        logic [ADDR_W-1:0] base;
        base  = {addr[ADDR_W-1:2], 2'b00};
        d.hi  = addr[1];
        d.sel = SEL_NONE;
        if (!addr[0]) begin
            unique case (base)
                OFS_STAT: d.sel = SEL_STAT;
                OFS_EN:   d.sel = SEL_EN;
                OFS_TYPE: d.sel = SEL_TYPE;
                OFS_LVL:  d.sel = SEL_LVL;
                OFS_HOLD: d.sel = SEL_HOLD;
                OFS_FALL: d.sel = SEL_FALL;
                OFS_RISE: d.sel = SEL_RISE;
                default:  d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] type_i,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] hold_i,
    input  logic [NPINS-1:0] fall_i,
    input  logic [NPINS-1:0] rise_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] stat_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] stat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic up, down, evt;
        always_comb begin
            up   = cur_i[p] & ~prev_q[p];
            down = ~cur_i[p] & prev_q[p];
            if (type_i[p]) evt = (up & rise_i[p]) | (down & fall_i[p]);
            else           evt = lvl_i[p] ? cur_i[p] : ~cur_i[p];
            if (type_i[p] && hold_i[p]) stat_d[p] = evt | (stat_q[p] & ~clr_i[p]);
            else                        stat_d[p] = evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int HALF  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [HALF-1:0]   wdata_i,
    input  logic [NPINS-1:0]  stat_i,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  type_o,
    output logic [NPINS-1:0]  lvl_o,
    output logic [NPINS-1:0]  hold_o,
    output logic [NPINS-1:0]  fall_o,
    output logic [NPINS-1:0]  rise_o,
    output logic [NPINS-1:0]  clr_o,
    output logic [HALF-1:0]   rdata_o
);

    reg_dec_t         dec;
    logic [NPINS-1:0] en_q, type_q, lvl_q, hold_q, fall_q, rise_q;
    logic [NPINS-1:0] rd_word;

    assign dec = decode_addr(addr_i);

    function automatic logic [NPINS-1:0] merge(logic [NPINS-1:0] old, logic hi,
                                               logic [HALF-1:0] d);
        logic [NPINS-1:0] r;
        r = old;
        if (hi) r[HALF +: HALF] = d;
        else    r[0 +: HALF]    = d;
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            type_q <= '0;
            lvl_q  <= '0;
            hold_q <= '0;
            fall_q <= '0;
            rise_q <= '0;
        end else if (wr_i) begin
            unique case (dec.sel)
                SEL_EN:   en_q   <= merge(en_q,   dec.hi, wdata_i);
                SEL_TYPE: type_q <= merge(type_q, dec.hi, wdata_i);
                SEL_LVL:  lvl_q  <= merge(lvl_q,  dec.hi, wdata_i);
                SEL_HOLD: hold_q <= merge(hold_q, dec.hi, wdata_i);
                SEL_FALL: fall_q <= merge(fall_q, dec.hi, wdata_i);
                SEL_RISE: rise_q <= merge(rise_q, dec.hi, wdata_i);
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_i && dec.sel == SEL_STAT) clr_o = merge('0, dec.hi, wdata_i);
    end

    always_comb begin
        unique case (dec.sel)
            SEL_STAT: rd_word = stat_i;
            SEL_EN:   rd_word = en_q;
            SEL_TYPE: rd_word = type_q;
            SEL_LVL:  rd_word = lvl_q;
            SEL_HOLD: rd_word = hold_q;
            SEL_FALL: rd_word = fall_q;
            SEL_RISE: rd_word = rise_q;
            default:  rd_word = '0;
        endcase
        rdata_o = dec.hi ? rd_word[HALF +: HALF] : rd_word[0 +: HALF];
    end

    assign en_o   = en_q;
    assign type_o = type_q;
    assign lvl_o  = lvl_q;
    assign hold_o = hold_q;
    assign fall_o = fall_q;
    assign rise_o = rise_q;

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
    parameter int NPINS = 32,
    parameter int HALF  = 16,
    localparam int IDX_W = $clog2(NPINS),
    localparam int HW    = $clog2(HALF)
) (
    input  logic [NPINS-1:0] pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] pin_o
);

    logic [HALF-1:0] half_v [2];
    logic [HW-1:0]   half_idx [2];
    logic            half_any [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            half_v[h]   = pend_i[h*HALF +: HALF];
            half_any[h] = |half_v[h];
            half_idx[h] = '0;
            for (int i = HALF - 1; i >= 0; i--) begin
                if (half_v[h][i]) half_idx[h] = HW'(i);
            end
        end
    end

    always_comb begin
        valid_o = half_any[0] | half_any[1];
        if (half_any[0])      pin_o = IDX_W'(half_idx[0]);
        else if (half_any[1]) pin_o = IDX_W'(HALF) + IDX_W'(half_idx[1]);
        else                  pin_o = '0;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int HALF      = NPINS / 2,
    parameter int SYNC_STGS = 2,
    localparam int IDX_W    = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [HALF-1:0]   reg_wdata_i,
    output logic [HALF-1:0]   reg_rdata_o,
    output logic              irq_o,
    output logic              irq_valid_o,
    output logic [IDX_W-1:0]  irq_pin_o
);

    logic [NPINS-1:0] cur_w;
    logic [NPINS-1:0] stat_w, en_w, type_w, lvl_w, hold_w, fall_w, rise_w, clr_w;
    logic [NPINS-1:0] pend_w;

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (cur_w)
    );

    gpio_irq_regs #(.NPINS(NPINS), .HALF(HALF)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (stat_w),
        .en_o    (en_w),
        .type_o  (type_w),
        .lvl_o   (lvl_w),
        .hold_o  (hold_w),
        .fall_o  (fall_w),
        .rise_o  (rise_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata_o)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (cur_w),
        .type_i (type_w),
        .lvl_i  (lvl_w),
        .hold_i (hold_w),
        .fall_i (fall_w),
        .rise_i (rise_w),
        .clr_i  (clr_w),
        .stat_o (stat_w)
    );

    assign pend_w = stat_w & en_w;
    assign irq_o  = |pend_w;

    gpio_irq_prio #(.NPINS(NPINS), .HALF(HALF)) u_prio (
        .pend_i  (pend_w),
        .valid_o (irq_valid_o),
        .pin_o   (irq_pin_o)
    );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NPINS = 32,
    localparam int IDX_W = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             irq_valid_o,
    input logic [IDX_W-1:0] irq_pin_o,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] type_q,
    input logic [NPINS-1:0] hold_q,
    input logic [NPINS-1:0] clr_mask
);

    logic [NPINS-1:0] below_mask;
    logic [NPINS-1:0] keep_w;

    always_comb begin
        below_mask = (NPINS'(1) << irq_pin_o) - NPINS'(1);
        keep_w     = stat_q & type_q & hold_q & ~clr_mask;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (en_q == '0 && type_q == '0 && hold_q == '0));

    assert_hold_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(keep_w) & ~stat_q) == '0));

    assert_line_matches_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == irq_valid_o);

    assert_reported_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (stat_q[irq_pin_o] && en_q[irq_pin_o]));

    assert_no_lower_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ((stat_q & en_q & below_mask) == '0));

    assert_idle_pin_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> irq_pin_o == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .irq_valid_o (irq_valid_o),
    .irq_pin_o   (irq_pin_o),
    .stat_q      (stat_w),
    .en_q        (en_w),
    .type_q      (type_w),
    .hold_q      (hold_w),
    .clr_mask    (clr_w)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '1;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, valid;
    logic [4:0]  pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_valid_o (valid),
        .irq_pin_o   (pin)
    );

    // {address, write data, expected read-back}
    localparam logic [37:0] VEC [9] = '{
        {6'h0C, 16'hA5A5, 16'hA5A5},
        {6'h0E, 16'h5A5A, 16'h5A5A},
        {6'h10, 16'h1234, 16'h1234},
        {6'h16, 16'h8001, 16'h8001},
        {6'h18, 16'h00F0, 16'h00F0},
        {6'h22, 16'h0F0F, 16'h0F0F},
        {6'h24, 16'hFFFF, 16'hFFFF},
        {6'h04, 16'hBEEF, 16'h0000},
        {6'h08, 16'hFFFF, 16'h0000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(logic [5:0] a, output logic [15:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(int p, logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    task automatic clear_cfg();
        for (int a = 6'h0C; a <= 6'h26; a += 2) wreg(6'(a), 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        // R1: reset state
        waitn(3);
        rreg(6'h08, d); chk("R1 status low in reset", d, 0);
        rreg(6'h0C, d); chk("R1 enable low in reset", d, 0);
        chk("R1 irq in reset", irq, 0);
        chk("R1 valid in reset", valid, 0);
        chk("R1 pin in reset", pin, 0);
        @(negedge clk); rst_n = 1'b1;
        waitn(6);
        rreg(6'h08, d); chk("R3 inactive low-active pins", d, 0);
        rreg(6'h0A, d); chk("R3 inactive low-active pins high", d, 0);

        // R2/R11: register table walk
        for (int i = 0; i < 9; i++) begin
            wreg(VEC[i][37:32], VEC[i][31:16]);
            rreg(VEC[i][37:32], d);
            chk($sformatf("R2 R11 readback vector %0d", i), d, VEC[i][15:0]);
        end
        rreg(6'h0E, d); chk("R2 upper enable unaffected by lower write", d, 16'h5A5A);
        clear_cfg();
        waitn(3);

        // R3: level pins, latency and polarity
        setpin(5, 1'b0);
        waitn(2);
        rreg(6'h08, d); chk("R3 latency not yet", d[5], 0);
        waitn(1);
        rreg(6'h08, d); chk("R3 active-low pending", d[5], 1);
        chk("R8 irq while disabled", irq, 0);
        wreg(6'h0C, 16'h0020);
        chk("R8 irq enabled", irq, 1);
        chk("R9 pin 5", pin, 5);
        setpin(5, 1'b1);
        waitn(3);
        rreg(6'h08, d); chk("R3 level follows input back", d[5], 0);
        chk("R10 valid none", valid, 0);
        chk("R10 pin none", pin, 0);
        wreg(6'h16, 16'h0004);
        waitn(1);
        rreg(6'h0A, d); chk("R3 active-high pin 18", d, 16'h0004);
        setpin(18, 1'b0);
        waitn(3);
        rreg(6'h0A, d); chk("R3 active-high released", d, 16'h0000);
        clear_cfg();

        // R4/R5/R7: edge pins 8..11, pulse pin 12
        wreg(6'h10, 16'h1F00);
        wreg(6'h18, 16'h0F00 & 16'h0700);
        wreg(6'h24, 16'h1500);
        wreg(6'h20, 16'h0600);
        waitn(3);
        setpin(8, 1'b0); waitn(4);
        rreg(6'h08, d); chk("R4 rising-only ignores fall", d[8], 0);
        setpin(8, 1'b1); waitn(3);
        rreg(6'h08, d); chk("R4 rising detected", d[8], 1);
        waitn(4);
        rreg(6'h08, d); chk("R5 held event stays", d[8], 1);
        wreg(6'h08, 16'h0000);
        rreg(6'h08, d); chk("R5 writing 0 keeps", d[8], 1);
        wreg(6'h08, 16'h0100);
        rreg(6'h08, d); chk("R7 write one clears", d[8], 0);

        setpin(9, 1'b0); waitn(3);
        rreg(6'h08, d); chk("R4 falling detected", d[9], 1);
        wreg(6'h08, 16'h0200);
        setpin(9, 1'b1); waitn(4);
        rreg(6'h08, d); chk("R4 falling-only ignores rise", d[9], 0);

        setpin(10, 1'b0); waitn(3);
        rreg(6'h08, d); chk("R4 both: fall", d[10], 1);
        wreg(6'h08, 16'h0400);
        setpin(10, 1'b1); waitn(3);
        rreg(6'h08, d); chk("R4 both: rise", d[10], 1);
        wreg(6'h08, 16'h0400);

        setpin(11, 1'b0); waitn(4);
        setpin(11, 1'b1); waitn(4);
        rreg(6'h08, d); chk("R4 no select no event", d[11], 0);

        setpin(12, 1'b0); waitn(4);
        setpin(12, 1'b1); waitn(3);
        rreg(6'h08, d); chk("R6 pulse high", d[12], 1);
        waitn(1);
        rreg(6'h08, d); chk("R6 pulse gone", d[12], 0);

        // R7: event and clear in the same cycle on pin 10
        setpin(10, 1'b0); waitn(3);
        wreg(6'h08, 16'h0400);
        rreg(6'h08, d); chk("R7 plain clear pin 10", d[10], 0);
        setpin(10, 1'b1);
        waitn(1);
        @(negedge clk);
        wr = 1'b1; addr = 6'h08; wdata = 16'h0400;
        @(negedge clk);
        wr = 1'b0;
        rreg(6'h08, d); chk("R7 event wins over clear", d[10], 1);
        wreg(6'h08, 16'h0400);
        rreg(6'h08, d); chk("R7 later clear", d[10], 0);
        clear_cfg();

        // R9: priority ordering
        pins = '1;
        waitn(4);
        wreg(6'h14, 16'hFFFF);
        wreg(6'h16, 16'hFFFF);
        wreg(6'h0E, 16'h0024);
        chk("R9 upper half index plus 16", pin, 18);
        chk("R8 irq from upper half", irq, 1);
        wreg(6'h0C, 16'h8008);
        chk("R9 lower half first", pin, 3);
        setpin(3, 1'b0); waitn(3);
        chk("R9 next lowest pin", pin, 15);
        setpin(15, 1'b0); waitn(3);
        chk("R9 fall back to upper half", pin, 18);

        // R11: unmapped writes ignored
        wreg(6'h06, 16'hFFFF);
        wreg(6'h1C, 16'hFFFF);
        rreg(6'h0E, d); chk("R11 enable unchanged", d, 16'h0024);
        rreg(6'h1C, d); chk("R11 unmapped read zero", d, 0);

        wreg(6'h0C, 16'h0000);
        wreg(6'h0E, 16'h0000);
        chk("R10 valid after disable", valid, 0);
        chk("R10 pin after disable", pin, 0);
        chk("R8 irq after disable", irq, 0);
        finish_run();
    end

endmodule